// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Whole-Line Refill

This block is a read-only cache that sits between a processor load port and a word-wide memory. It holds a parameterised number of lines, and each line carries several data words with one tag and one valid flag. A byte address is split into a tag, a line index, a word-within-line field and a byte offset. The line index picks exactly one slot. The access hits when that slot is valid and its stored tag equals the address tag, and the selected word is then returned from the data store.

On a miss the slot is replaced. The controller clears the slot's valid flag and forms the line-aligned byte address by clearing the word and byte fields. It then reads every word of the line from memory, one request at a time and in ascending order, and writes each returned word into the data store. Tag and valid are written together with the last word. The requested word goes back to the processor in the cycle after the last memory beat. Each response reports whether it was a hit, a miss on an empty slot, or a miss that displaced another line. While a lookup or a refill is in progress, the request side is held off.

Top module: `dm_line_cache`

## Requirements
- R1: After reset every slot is empty, `req_ready` is 1, and `rsp_valid` and `mem_rd_req` are 0. The first access to any slot is therefore reported as a miss on an empty slot.
- R2: With default parameters, address bits [3:2] select the word within a line, bits [5:4] select the slot, and bits [31:6] form the tag. Bits [1:0] have no effect: two addresses that differ only there return the same word.
- R3: A hit returns the addressed word with `rsp_kind` = 2'b00. `rsp_valid` is high for exactly one cycle, in the second cycle after the accepting clock edge, and no memory read is issued.
- R4: A miss issues exactly one memory read per line word (four by default), one outstanding at a time. The reads use byte addresses base, base+4, base+8 and base+12 in that order, where base is the request address with bits [3:0] cleared.
- R5: A miss response carries the addressed word from memory and comes in the cycle after the cycle in which the last `mem_rd_valid` beat is presented. `rsp_kind` is 2'b01 when the slot was empty and 2'b10 when the slot held a line with another tag. 2'b11 never occurs.
- R6: `req_ready` is low from the cycle after an accepting edge until the response cycle, and is high again in the response cycle. A request held there is accepted at the next edge.
- R7: A slot's valid flag is raised only by the last refill beat. After a refill, every word of that line hits.
- R8: Addresses with the same slot index and different tags evict each other, so alternating between them misses every time with `rsp_kind` = 2'b10. A line in a different slot is left undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can take a request this cycle |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | WORD_W | Returned word |
| rsp_kind | output | 2 | 00 hit, 01 miss on empty slot, 10 miss displacing a line |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | ADDR_W | Byte address of the memory read |
| mem_rd_valid | input | 1 | Memory read data present |
| mem_rd_data | input | WORD_W | Memory read data |

## Verification
Two events can fall in the same cycle: the response that ends a refill, and the acceptance of the next request. The next request can even target the line that is still being closed. The bench provokes this by presenting a second address in the same line as soon as a miss is accepted and holding it through the refill. It then checks that `req_ready` rises exactly in the miss-response cycle and that the held request is taken at the next edge. The held request must hit, returning the freshly written word with no memory traffic. Refills are also run with a slow memory, so that the spacing of the beats does not affect order or response timing.

// File: rtl/cache_pkg.sv
package cache_pkg;

  // Response classification seen on rsp_kind
  typedef enum logic [1:0] {
    KIND_HIT  = 2'b00,
    KIND_COLD = 2'b01,
    KIND_HOT  = 2'b10
  } access_kind_e;

  // Controller states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } ctrl_state_e;

endpackage

// File: rtl/cache_sdp_ram.sv
// Simple dual-port store: one synchronous write port, one registered read port.
module cache_sdp_ram #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/cache_refill_seq.sv
// Issues one memory read per line word, ascending, one outstanding at a time.
module cache_refill_seq #(
  parameter int ADDR_W = 32,
  parameter int WIB_W  = 2,
  parameter int OFF_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [ADDR_W-WIB_W-OFF_W-1:0] line_addr,
  input  logic                          mem_rd_valid,
  output logic                          mem_rd_req,
  output logic [ADDR_W-1:0]             mem_rd_addr,
  output logic                          beat_wr,
  output logic [WIB_W-1:0]              beat_idx,
  output logic                          beat_last
);
  localparam int LINE_W = ADDR_W - WIB_W - OFF_W;
  localparam logic [WIB_W-1:0] LAST_BEAT = {WIB_W{1'b1}};

  logic              busy_q;
  logic [WIB_W-1:0]  cnt_q;
  logic [WIB_W-1:0]  cnt_nxt;
  logic [LINE_W-1:0] line_q;

  assign cnt_nxt   = cnt_q + 1'b1;
  assign beat_wr   = busy_q & mem_rd_valid;
  assign beat_idx  = cnt_q;
  assign beat_last = beat_wr & (cnt_q == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      line_q      <= '0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      mem_rd_req <= 1'b0;
      if (start) begin
        busy_q      <= 1'b1;
        cnt_q       <= '0;
        line_q      <= line_addr;
        mem_rd_req  <= 1'b1;
        mem_rd_addr <= {line_addr, {WIB_W{1'b0}}, {OFF_W{1'b0}}};
      end else if (beat_wr) begin
        if (cnt_q == LAST_BEAT) begin
          busy_q <= 1'b0;
        end else begin
          cnt_q       <= cnt_nxt;
          mem_rd_req  <= 1'b1;
          mem_rd_addr <= {line_q, cnt_nxt, {OFF_W{1'b0}}};
        end
      end
    end
  end
endmodule

// File: rtl/dm_line_cache.sv
module dm_line_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINES      = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic [1:0]        rsp_kind,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [WORD_W-1:0] mem_rd_data
);
  localparam int OFF_W   = $clog2(WORD_W / 8);
  localparam int WIB_W   = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - IDX_W - WIB_W - OFF_W;
  localparam int DADDR_W = IDX_W + WIB_W;

  // Request address fields
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [WIB_W-1:0] req_wib;
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx = req_addr[OFF_W+WIB_W +: IDX_W];
  assign req_wib = req_addr[OFF_W +: WIB_W];

  ctrl_state_e      state_q;
  logic [TAG_W-1:0] a_tag_q;
  logic [IDX_W-1:0] a_idx_q;
  logic [WIB_W-1:0] a_wib_q;
  logic [LINES-1:0] line_valid_q;
  access_kind_e     kind_hold_q;
  logic [WORD_W-1:0] pick_q;

  logic              accept;
  logic              lookup_hit;
  logic              fill_start;
  logic [TAG_W-1:0]  tag_rd;
  logic [WORD_W-1:0] data_rd;
  logic              beat_wr;
  logic [WIB_W-1:0]  beat_idx;
  logic              fill_last;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid & req_ready;
  assign lookup_hit = line_valid_q[a_idx_q] & (tag_rd == a_tag_q);
  assign fill_start = (state_q == ST_LOOK) & ~lookup_hit;

  // Tag store: read on accept, written when the last refill word lands
  cache_sdp_ram #(.DW(TAG_W), .AW(IDX_W)) u_tag_ram (
    .clk   (clk),
    .we    (fill_last),
    .waddr (a_idx_q),
    .wdata (a_tag_q),
    .re    (accept),
    .raddr (req_idx),
    .rdata (tag_rd)
  );

  // Data store: one word per entry, addressed by {slot, word}
  cache_sdp_ram #(.DW(WORD_W), .AW(DADDR_W)) u_data_ram (
    .clk   (clk),
    .we    (beat_wr),
    .waddr ({a_idx_q, beat_idx}),
    .wdata (mem_rd_data),
    .re    (accept),
    .raddr ({req_idx, req_wib}),
    .rdata (data_rd)
  );

  cache_refill_seq #(.ADDR_W(ADDR_W), .WIB_W(WIB_W), .OFF_W(OFF_W)) u_refill (
    .clk          (clk),
    .rst          (rst),
    .start        (fill_start),
    .line_addr    ({a_tag_q, a_idx_q}),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .beat_wr      (beat_wr),
    .beat_idx     (beat_idx),
    .beat_last    (fill_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      a_tag_q      <= '0;
      a_idx_q      <= '0;
      a_wib_q      <= '0;
      line_valid_q <= '0;
      kind_hold_q  <= KIND_COLD;
      pick_q       <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_kind     <= KIND_HIT;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            a_tag_q <= req_tag;
            a_idx_q <= req_idx;
            a_wib_q <= req_wib;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (lookup_hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= data_rd;
            rsp_kind  <= KIND_HIT;
            state_q   <= ST_IDLE;
          end else begin
            kind_hold_q           <= line_valid_q[a_idx_q] ? KIND_HOT : KIND_COLD;
            line_valid_q[a_idx_q] <= 1'b0;
            state_q               <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (beat_wr && (beat_idx == a_wib_q)) pick_q <= mem_rd_data;
          if (fill_last) begin
            line_valid_q[a_idx_q] <= 1'b1;
            rsp_valid <= 1'b1;
            rsp_data  <= (beat_idx == a_wib_q) ? mem_rd_data : pick_q;
            rsp_kind  <= kind_hold_q;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dm_line_cache_chk.sv
module dm_line_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINES      = 4,
  parameter int LINE_WORDS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic [LINES-1:0]  line_valid,
  input logic              fill_last
);
  localparam int CNT_W   = $clog2(LINE_WORDS) + 1;
  localparam int BYTES   = WORD_W / 8;
  localparam int LINE_OB = $clog2(LINE_WORDS * BYTES);

  logic [CNT_W-1:0]  beats_q;
  logic [ADDR_W-1:0] prev_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beats_q     <= '0;
      prev_addr_q <= '0;
    end else if (req_valid && req_ready) begin
      beats_q <= '0;
    end else if (mem_rd_req) begin
      beats_q     <= beats_q + 1'b1;
      prev_addr_q <= mem_rd_addr;
    end
  end

  // R6: the request side closes right after an acceptance
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R3: response strobe lasts one cycle
  p_rsp_single_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R5: kind code 2'b11 never reported
  p_kind_legal_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_kind != 2'b11));

  // R4: memory is read only while the request side is closed
  p_mem_only_busy_r4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !req_ready);

  // R4: no more than one read per line word per request
  p_beat_limit_r4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (beats_q < CNT_W'(LINE_WORDS)));

  // R4: first read is line aligned
  p_base_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && beats_q == '0) |-> (mem_rd_addr[LINE_OB-1:0] == '0));

  // R4: later reads step by one word
  p_beat_step_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && beats_q != '0) |-> (mem_rd_addr == prev_addr_q + ADDR_W'(BYTES)));

  // R7: a valid flag rises only with the last refill beat
  p_valid_rise_r7: assert property (@(posedge clk) disable iff (rst)
    ((line_valid & ~$past(line_valid)) != '0) |-> $past(fill_last));
endmodule

bind dm_line_cache dm_line_cache_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINES(LINES), .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_kind    (rsp_kind),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .line_valid  (line_valid_q),
  .fill_last   (fill_last)
);

// File: tb/test_dm_line_cache.sv
`timescale 1ns/1ps
module test_dm_line_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [1:0]  rsp_kind;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dm_line_cache i_dm_line_cache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_kind(rsp_kind),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [31:0] mval(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
  endfunction

  // Memory model with adjustable latency
  logic        pend;
  logic [31:0] paddr;
  int          cd;
  always @(posedge clk) begin
    if (rst) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= '0;
      pend         <= 1'b0;
      paddr        <= '0;
      cd           <= 0;
    end else begin
      mem_rd_valid <= 1'b0;
      if (mem_rd_req) begin
        pend  <= 1'b1;
        paddr <= mem_rd_addr;
        cd    <= lat - 1;
      end else if (pend) begin
        if (cd == 0) begin
          mem_rd_valid <= 1'b1;
          mem_rd_data  <= mval(paddr);
          pend         <= 1'b0;
        end else begin
          cd <= cd - 1;
        end
      end
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Present a request at a falling edge and hold it until accepted
  task automatic send(logic [31:0] a);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Wait for the response of the request accepted just before and judge it
  task automatic wait_rsp(logic [31:0] a, logic [1:0] kind, bit miss, string dreq);
    int n = 0;
    int nreq = 0;
    int lastv = -10;
    bit got = 1'b0;
    bit ready_bad = 1'b0;
    logic [31:0] seen [4];
    logic [31:0] base;
    base = {a[31:4], 4'h0};
    while (!got && n < 80) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (mem_rd_req) begin
        if (nreq < 4) seen[nreq] = mem_rd_addr;
        nreq++;
      end
      if (mem_rd_valid) lastv = n;
      if (rsp_valid) got = 1'b1;
      else if (req_ready) ready_bad = 1'b1;
    end
    check(got, "R3 response arrives", 32'(got), 32'd1);
    check(rsp_data == mval({a[31:2], 2'b00}), dreq, rsp_data, mval({a[31:2], 2'b00}));
    check(rsp_kind == kind, "R5 response kind", 32'(rsp_kind), 32'(kind));
    check(req_ready, "R6 ready in response cycle", 32'(req_ready), 32'd1);
    if (!miss) begin
      check(n == 1, "R3 hit latency", 32'(n), 32'd1);
      check(nreq == 0, "R3 no memory read on hit", 32'(nreq), 32'd0);
    end else begin
      check(nreq == 4, "R4 beat count", 32'(nreq), 32'd4);
      for (int b = 0; b < 4; b++)
        check(seen[b] == base + 32'(4 * b), "R4 beat address order", seen[b], base + 32'(4 * b));
      check(lastv == n - 1, "R5 response after last beat", 32'(lastv), 32'(n - 1));
      check(!ready_bad, "R6 ready low during refill", 32'(ready_bad), 32'd0);
    end
  endtask

  task automatic access(logic [31:0] a, logic [1:0] kind, bit miss, string dreq);
    send(a);
    wait_rsp(a, kind, miss, dreq);
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
    check(mem_rd_req == 1'b0, "R1 no memory read after reset", 32'(mem_rd_req), 32'd0);
  endtask

  task automatic t_cold_then_hits;
    access(32'h0000_0104, 2'b01, 1'b1, "R1 cold miss data");
    for (int w = 0; w < 4; w++)
      access(32'h0000_0100 + 32'(4 * w), 2'b00, 1'b0, "R7 hit on refilled line");
  endtask

  task automatic t_byte_offset;
    access(32'h0000_0107, 2'b00, 1'b0, "R2 byte offset ignored");
    access(32'h0000_0109, 2'b00, 1'b0, "R2 word field select");
  endtask

  task automatic t_conflict;
    access(32'h0000_0110, 2'b01, 1'b1, "R8 other slot fill");
    access(32'h0000_0104, 2'b00, 1'b0, "R8 other slot undisturbed");
    access(32'h0000_0140, 2'b10, 1'b1, "R8 conflict evicts");
    access(32'h0000_0100, 2'b10, 1'b1, "R8 conflict thrash");
    access(32'h0000_0144, 2'b10, 1'b1, "R8 conflict thrash again");
    access(32'h0000_0118, 2'b00, 1'b0, "R8 neighbour slot kept");
  endtask

  task automatic t_last_word;
    access(32'h0000_022C, 2'b01, 1'b1, "R5 last word of line");
    access(32'h0000_03E0, 2'b10, 1'b1, "R5 first word after displacement");
  endtask

  task automatic t_slow_memory;
    lat = 4;
    access(32'h0000_5038, 2'b01, 1'b1, "R4 refill with slow memory");
    access(32'h0000_5034, 2'b00, 1'b0, "R7 hit after slow refill");
    lat = 1;
  endtask

  // Refill response and next acceptance in the same cycle, same line
  task automatic t_back_to_back;
    send(32'h0000_0824);
    req_valid = 1'b1;
    req_addr  = 32'h0000_082C;
    wait_rsp(32'h0000_0824, 2'b10, 1'b1, "R6 refill with held request");
    check(req_valid && req_ready, "R6 held request taken at response", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(32'h0000_082C, 2'b00, 1'b0, "R7 hit right after refill");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cold_then_hits();
    t_byte_offset();
    t_conflict();
    t_last_word();
    t_slow_memory();
    t_back_to_back();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule